// File: doc/BRIEF.md
# Master-to-Slave Serial Status Link

This block sends a small converter-control status word from a master controller to one or more slave controllers over a four-wire synchronous serial link of the SPI kind. On the master side, a set of measured quantities is compared against per-channel limits to form a protection flag. That flag is packed with a three-bit output-level number and one current-direction bit per converter arm into an eight-bit frame. The frame is shifted out again and again, with no pause between frames.

On the slave side, the serial lines are synchronised into the system clock and the frame is reassembled. The fields are presented in parallel once a complete frame has been seen. The slave raises a fault output in three cases: when the received protection flag reports a problem, when a frame carries a level number outside the legal range, or when the link goes quiet for too long.

Both ends share one top module so that they can be used together or apart. The transmit lines are outputs, and the receive lines are separate inputs. The link is a broadcast of state, so it has no back-pressure: a new frame always replaces the previous one, and the receiver never stalls the transmitter.

Top module: `spi_status_link`

## Requirements
- R1: A frame is 8 bits sent most significant bit first. Bits [7:5] hold the level number. Bits [4:1] hold the arm directions, with `tx_arm_dir[0]` (arm A) in bit 4 through `tx_arm_dir[3]` (arm D) in bit 1. Bit [0] is the protection flag.
- R2: The serial clock is the system clock divided by 16, with 8 cycles low and 8 cycles high. `tx_mosi` changes only on a falling edge of `tx_sclk`. The receiver samples on the rising edge.
- R3: Frames run back to back every 128 system clocks. Chip select is low from the first falling edge of a frame. It rises 4 system clocks after the eighth rising edge of the serial clock and stays high for 4 system clocks.
- R4: The transmitted protection flag is 0 when any measurement is strictly greater than its own threshold, and 1 otherwise. A measurement equal to its threshold is not a fault.
- R5: The slave updates `rx_level`, `rx_arm_dir` and `rx_prot_ok` only when chip select rises after exactly 8 rising edges of the serial clock. A frame with fewer bits leaves the outputs unchanged.
- R6: A complete frame whose level number is above 4 is a framing error. The outputs keep their previous values, and `rx_fault` is forced to 1 until the next valid frame.
- R7: If no valid frame arrives for 4 frame periods (512 system clocks), `rx_fault` goes to 1 while the other outputs keep their last values. The next valid frame clears this condition.
- R8: `rx_fault` is 1 whenever the last valid frame carried a protection flag of 0, or a framing error or timeout is pending. Otherwise it is 0.
- R9: During reset, `tx_cs_n` and `tx_sclk` are high, `rx_level`, `rx_arm_dir` and `rx_prot_ok` are 0, and `rx_fault` is 1. `rx_fault` stays at 1 until the first valid frame arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 times the serial clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_level | input | 3 | Level number to transmit |
| tx_arm_dir | input | 4 | Arm current directions, bit 0 = arm A |
| meas_flat | input | 72 | Six 12-bit measurements, channel i at [12i+11:12i] |
| thr_flat | input | 72 | Six 12-bit thresholds, same packing |
| tx_sclk | output | 1 | Serial clock to slaves |
| tx_cs_n | output | 1 | Frame select, active low |
| tx_mosi | output | 1 | Serial data to slaves |
| rx_sclk | input | 1 | Serial clock from master |
| rx_cs_n | input | 1 | Frame select from master |
| rx_mosi | input | 1 | Serial data from master |
| rx_level | output | 3 | Last valid received level number |
| rx_arm_dir | output | 4 | Last valid received arm directions, bit 0 = arm A |
| rx_prot_ok | output | 1 | Last valid received protection flag |
| rx_fault | output | 1 | Slave fault, active high |

## Verification
The hardest receiver states to reach are the framing error, the partial frame and the silent-link timeout. A correct master only ever sends well-formed frames unless it is told to send a bad level.

The bench reaches the framing error by driving a level of 5 into the master, which transmits it without checking. It reaches the partial frame and the timeout by switching the receive inputs from the master's lines to bench-driven lines. On those lines it sends a short frame by hand and then holds chip select high, so that the quiet-time window expires while the retained fields are watched.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int FRAME_BITS = 8;
  localparam int LEVEL_W    = 3;
  localparam int NUM_ARMS   = 4;
  localparam int MAX_LEVEL  = 4;
  localparam int PROT_POS   = 0;
  localparam int ARM_TOP    = PROT_POS + NUM_ARMS;  // wire bit holding arm A
  localparam int LEVEL_LSB  = ARM_TOP + 1;
endpackage

// File: rtl/sl_fault_detect.sv
module sl_fault_detect #(
  parameter int NUM_MEAS = 6,
  parameter int MEAS_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_MEAS*MEAS_W-1:0] meas_flat,
  input  logic [NUM_MEAS*MEAS_W-1:0] thr_flat,
  output logic                       fault_q
);
  logic [NUM_MEAS-1:0] over;

  for (genvar i = 0; i < NUM_MEAS; i++) begin : g_cmp
    assign over[i] = meas_flat[i*MEAS_W +: MEAS_W] > thr_flat[i*MEAS_W +: MEAS_W];
  end

  // fail-safe: report a fault until the first comparison is registered
  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b1;
    else        fault_q <= |over;
  end
endmodule

// File: rtl/sl_spi_tx.sv
module sl_spi_tx
  import sl_pkg::*;
#(
  parameter int CLK_DIV = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi
);
  localparam int FRAME_CLKS = CLK_DIV * FRAME_BITS;
  localparam int POS_W      = $clog2(FRAME_CLKS);
  localparam int DIV_W      = $clog2(CLK_DIV);
  localparam int HALF       = CLK_DIV / 2;
  localparam int CS_OFF     = FRAME_CLKS - CLK_DIV / 4;

  logic [POS_W-1:0]      pos, pos_n;
  logic [DIV_W-1:0]      phase_n;
  logic [FRAME_BITS-1:0] sreg;

  always_comb begin
    pos_n   = (pos == POS_W'(FRAME_CLKS - 1)) ? '0 : pos + 1'b1;
    phase_n = pos_n[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= POS_W'(FRAME_CLKS - 1);
      sclk <= 1'b1;
      cs_n <= 1'b1;
      sreg <= '0;
    end else begin
      pos  <= pos_n;
      sclk <= phase_n >= DIV_W'(HALF);
      cs_n <= pos_n >= POS_W'(CS_OFF);
      if (pos_n == '0)
        sreg <= frame;
      else if (phase_n == '0)
        sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign mosi = sreg[FRAME_BITS-1];
endmodule

// File: rtl/sl_spi_rx.sv
module sl_spi_rx
  import sl_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_in,
  input  logic                cs_n_in,
  input  logic                mosi_in,
  output logic [LEVEL_W-1:0]  level,
  output logic [NUM_ARMS-1:0] arm_dir,
  output logic                prot_ok,
  output logic                fault,
  output logic                frame_bad,
  output logic                timed_out
);
  localparam int TO_W = $clog2(TIMEOUT_CLKS + 1);

  logic [2:0]            sclk_s, cs_s;
  logic [1:0]            mosi_s;
  logic [FRAME_BITS-1:0] shreg;
  logic [3:0]            bitcnt;
  logic                  link_err;
  logic [TO_W-1:0]       to_cnt;
  logic                  sclk_rise, cs_rise, cs_fall, cs_low, frame_done, frame_good;
  logic [LEVEL_W-1:0]    lvl_rx;

  always_comb begin
    sclk_rise  = sclk_s[1] & ~sclk_s[2];
    cs_rise    = cs_s[1] & ~cs_s[2];
    cs_fall    = ~cs_s[1] & cs_s[2];
    cs_low     = ~cs_s[1];
    lvl_rx     = shreg[FRAME_BITS-1 -: LEVEL_W];
    frame_done = cs_rise && (bitcnt == 4'(FRAME_BITS));
    frame_bad  = frame_done && (lvl_rx > LEVEL_W'(MAX_LEVEL));
    frame_good = frame_done && !frame_bad;
    fault      = link_err | timed_out | ~prot_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_s    <= 3'b111;
      cs_s      <= 3'b111;
      mosi_s    <= '0;
      shreg     <= '0;
      bitcnt    <= '0;
      level     <= '0;
      arm_dir   <= '0;
      prot_ok   <= 1'b0;
      link_err  <= 1'b1;
      to_cnt    <= '0;
      timed_out <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_in};
      cs_s   <= {cs_s[1:0], cs_n_in};
      mosi_s <= {mosi_s[0], mosi_in};

      if (cs_fall)
        bitcnt <= '0;
      else if (sclk_rise && cs_low) begin
        shreg <= {shreg[FRAME_BITS-2:0], mosi_s[1]};
        if (bitcnt != 4'hF) bitcnt <= bitcnt + 1'b1;
      end

      if (frame_good) begin
        level <= lvl_rx;
        for (int k = 0; k < NUM_ARMS; k++) arm_dir[k] <= shreg[ARM_TOP - k];
        prot_ok  <= shreg[PROT_POS];
        link_err <= 1'b0;
      end else if (frame_bad) begin
        link_err <= 1'b1;
      end

      if (frame_good) begin
        to_cnt    <= '0;
        timed_out <= 1'b0;
      end else if (to_cnt == TO_W'(TIMEOUT_CLKS))
        timed_out <= 1'b1;
      else
        to_cnt <= to_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_status_link.sv
module spi_status_link
  import sl_pkg::*;
#(
  parameter int CLK_DIV        = 16,
  parameter int NUM_MEAS       = 6,
  parameter int MEAS_W         = 12,
  parameter int TIMEOUT_FRAMES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LEVEL_W-1:0]         tx_level,
  input  logic [NUM_ARMS-1:0]        tx_arm_dir,
  input  logic [NUM_MEAS*MEAS_W-1:0] meas_flat,
  input  logic [NUM_MEAS*MEAS_W-1:0] thr_flat,
  output logic                       tx_sclk,
  output logic                       tx_cs_n,
  output logic                       tx_mosi,
  input  logic                       rx_sclk,
  input  logic                       rx_cs_n,
  input  logic                       rx_mosi,
  output logic [LEVEL_W-1:0]         rx_level,
  output logic [NUM_ARMS-1:0]        rx_arm_dir,
  output logic                       rx_prot_ok,
  output logic                       rx_fault
);
  localparam int TIMEOUT_CLKS = TIMEOUT_FRAMES * CLK_DIV * FRAME_BITS;

  logic                  meas_fault;
  logic [FRAME_BITS-1:0] tx_frame;
  logic                  rx_frame_bad, rx_timed_out;

  sl_fault_detect #(.NUM_MEAS(NUM_MEAS), .MEAS_W(MEAS_W)) u_fault (
    .clk(clk), .rst_n(rst_n), .meas_flat(meas_flat), .thr_flat(thr_flat),
    .fault_q(meas_fault)
  );

  assign tx_frame[FRAME_BITS-1 -: LEVEL_W] = tx_level;
  assign tx_frame[PROT_POS]                = ~meas_fault;
  for (genvar k = 0; k < NUM_ARMS; k++) begin : g_pack
    assign tx_frame[ARM_TOP - k] = tx_arm_dir[k];
  end

  sl_spi_tx #(.CLK_DIV(CLK_DIV)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame(tx_frame),
    .sclk(tx_sclk), .cs_n(tx_cs_n), .mosi(tx_mosi)
  );

  sl_spi_rx #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_in(rx_sclk), .cs_n_in(rx_cs_n), .mosi_in(rx_mosi),
    .level(rx_level), .arm_dir(rx_arm_dir), .prot_ok(rx_prot_ok),
    .fault(rx_fault), .frame_bad(rx_frame_bad), .timed_out(rx_timed_out)
  );
endmodule

// File: rtl/spi_status_link_chk.sv
module spi_status_link_chk
  import sl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               tx_sclk,
  input logic               tx_cs_n,
  input logic               tx_mosi,
  input logic               rx_cs_n,
  input logic [LEVEL_W-1:0] rx_level,
  input logic               rx_fault,
  input logic               frame_bad
);
  // R2: data only moves when the serial clock falls
  a_r2_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_mosi) |-> $fell(tx_sclk));

  // R3: chip select releases while the serial clock is high
  a_r3_cs_rise_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_cs_n) |-> tx_sclk);

  // R6: presented level never leaves the legal range
  a_r6_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LEVEL_W'(MAX_LEVEL));

  // R6: a bad frame keeps the level and raises the fault
  a_r6_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> $stable(rx_level) && rx_fault);

  // R5: outputs only move while the select line is released
  a_r5_update_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_level) |-> rx_cs_n);
endmodule

bind spi_status_link spi_status_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_sclk(tx_sclk), .tx_cs_n(tx_cs_n),
  .tx_mosi(tx_mosi), .rx_cs_n(rx_cs_n), .rx_level(rx_level),
  .rx_fault(rx_fault), .frame_bad(rx_frame_bad)
);

// File: tb/spi_status_link_bench.sv
`timescale 1ns/1ps
module spi_status_link_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  tx_level = '0;
  logic [3:0]  tx_arm_dir = '0;
  logic [11:0] meas [6];
  logic [71:0] meas_flat, thr_flat;
  logic tx_sclk, tx_cs_n, tx_mosi;
  logic b_sclk = 1'b1, b_cs_n = 1'b1, b_mosi = 1'b0;
  logic use_tx = 1'b1;
  logic rx_sclk, rx_cs_n, rx_mosi;
  logic [2:0] rx_level;
  logic [3:0] rx_arm_dir;
  logic rx_prot_ok, rx_fault;

  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic [7:0] cap = '0, last_byte = '0;

  always_comb begin
    for (int i = 0; i < 6; i++) begin
      meas_flat[i*12 +: 12] = meas[i];
      thr_flat[i*12 +: 12]  = 12'd1000;
    end
  end

  assign rx_sclk = use_tx ? tx_sclk : b_sclk;
  assign rx_cs_n = use_tx ? tx_cs_n : b_cs_n;
  assign rx_mosi = use_tx ? tx_mosi : b_mosi;

  spi_status_link u_spi_status_link (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_arm_dir(tx_arm_dir),
    .meas_flat(meas_flat), .thr_flat(thr_flat),
    .tx_sclk(tx_sclk), .tx_cs_n(tx_cs_n), .tx_mosi(tx_mosi),
    .rx_sclk(rx_sclk), .rx_cs_n(rx_cs_n), .rx_mosi(rx_mosi),
    .rx_level(rx_level), .rx_arm_dir(rx_arm_dir),
    .rx_prot_ok(rx_prot_ok), .rx_fault(rx_fault)
  );

  // independent serial decoder of the transmit lines
  always @(posedge tx_sclk) if (!tx_cs_n) cap <= {cap[6:0], tx_mosi};
  always @(posedge tx_cs_n) last_byte <= cap;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_manual(input logic [7:0] b, input int nbits);
    b_cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      b_sclk = 1'b0;
      b_mosi = b[7-i];
      waitn(8);
      b_sclk = 1'b1;
      waitn(8);
    end
    waitn(4);
    b_cs_n = 1'b1;
  endtask

  // {level, dir, mode(0 none,1 over,2 equal), channel, exp_fault, exp_byte}
  localparam logic [20:0] VEC [6] = '{
    {3'd0, 4'b0000, 2'd0, 3'd0, 1'b0, 8'h01},
    {3'd4, 4'b0001, 2'd0, 3'd0, 1'b0, 8'h91},
    {3'd2, 4'b1000, 2'd1, 3'd0, 1'b1, 8'h42},
    {3'd1, 4'b0110, 2'd2, 3'd5, 1'b0, 8'h2D},
    {3'd3, 4'b1111, 2'd1, 3'd5, 1'b1, 8'h7E},
    {3'd4, 4'b0101, 2'd0, 3'd0, 1'b0, 8'h95}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, m, rises;
    logic prev;
    for (int i = 0; i < 6; i++) meas[i] = 12'd500;
    waitn(5);
    // R9: reset state
    chk("R9 cs_n", tx_cs_n, 1);
    chk("R9 sclk", tx_sclk, 1);
    chk("R9 rx_level", rx_level, 0);
    chk("R9 rx_arm_dir", rx_arm_dir, 0);
    chk("R9 rx_fault", rx_fault, 1);
    rst_n = 1'b1;

    // R1 R4 R5 R8: vector walk
    for (int v = 0; v < 6; v++) begin
      logic [20:0] e;
      e = VEC[v];
      tx_level   = e[20:18];
      tx_arm_dir = e[17:14];
      for (int i = 0; i < 6; i++) meas[i] = 12'd500;
      if (e[13:12] == 2'd1) meas[e[11:9]] = 12'd1001;
      if (e[13:12] == 2'd2) meas[e[11:9]] = 12'd1000;
      waitn(320);
      chk("R1 serial byte", last_byte, e[7:0]);
      chk("R5 rx_level", rx_level, e[20:18]);
      chk("R1 rx_arm_dir", rx_arm_dir, e[17:14]);
      chk("R4 rx_prot_ok", rx_prot_ok, !e[8]);
      chk("R8 rx_fault", rx_fault, e[8]);
    end

    // R3 R2: frame timing
    @(posedge tx_cs_n);
    n = 0;
    @(negedge clk);
    while (tx_cs_n) begin n++; @(negedge clk); end
    m = 0; rises = 0; prev = tx_sclk;
    while (!tx_cs_n) begin
      m++;
      if (tx_sclk && !prev) rises++;
      prev = tx_sclk;
      @(negedge clk);
    end
    chk("R3 cs high width", n, 4);
    chk("R3 cs low width", m, 124);
    chk("R2 sclk rises per frame", rises, 8);

    // R6: out-of-range level is a framing error
    tx_level = 3'd5; tx_arm_dir = 4'b0011;
    waitn(320);
    chk("R6 level held", rx_level, 4);
    chk("R6 dir held", rx_arm_dir, 4'b0101);
    chk("R6 fault forced", rx_fault, 1);
    tx_level = 3'd3;
    waitn(320);
    chk("R6 recovered level", rx_level, 3);
    chk("R6 recovered fault", rx_fault, 0);

    // R5: partial frame ignored, then full manual frame
    use_tx = 1'b0;
    waitn(20);
    send_manual(8'b010_1010_1, 5);
    waitn(10);
    chk("R5 partial level", rx_level, 3);
    chk("R5 partial dir", rx_arm_dir, 4'b0011);
    send_manual(8'b010_1010_1, 8);
    waitn(10);
    chk("R1 manual level", rx_level, 2);
    chk("R1 manual dir", rx_arm_dir, 4'b0101);
    chk("R8 manual fault", rx_fault, 0);

    // R7: quiet link times out
    waitn(440);
    chk("R7 before timeout", rx_fault, 0);
    waitn(100);
    chk("R7 timeout fault", rx_fault, 1);
    chk("R7 level retained", rx_level, 2);
    use_tx = 1'b1;
    waitn(320);
    chk("R7 cleared", rx_fault, 0);
    chk("R7 new level", rx_level, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule